// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is an SPI master that shifts words out on MOSI and takes words in on MISO, addressing up to four slaves through active-low select lines. Every slave has its own 32-bit setup word. The setup word gives the clock rest level, the sampling edge, the word length, the SCK half-period, the lead time from select to the first clock edge and the spacing between words. It also gives one of three select-line policies for that slave.

Software writes a setup word through a small write port. A write-protect input can lock all setup words. A word to send enters through a one-deep holding register, tagged with a slave index. The sequencer drives SCK, MOSI and the selects. When a word completes, it returns the received bits with a one-cycle valid strobe.

The select policies work as follows. With the normal policy, the select is released once nothing more is queued for that slave. With the hold policy, the select stays low until a different slave is addressed. With the forced-release policy, the select goes high after every word and stays high for a guaranteed minimum time.

Top module: `spi_cs_seq`

## Requirements
- R1: The setup word layout is: between-word delay in bits 31:24, pre-clock delay in bits 23:16, half-period divider in bits 15:8, length code in bits 7:4, hold flag in bit 3, forced-release flag in bit 2, phase flag in bit 1 and polarity flag in bit 0. All setup words reset to zero, so a slave that was never written does 8-bit words with SCK resting low. After reset `tx_ready` is 1, every select is high and `rx_valid` is 0.
- R2: The polarity flag sets the SCK rest level: 0 gives low and 1 gives high. SCK is back at that level whenever a word completes.
- R3: With phase=1, data is sampled on the leading SCK edge and changed on the trailing edge. With phase=0, data changes on the leading edge and is sampled on the trailing edge.
- R4: A length code n gives 8+n bits, and codes above 8 give 16 bits. Bits are sent MSB first. `rx_data` holds the received bits right-aligned, with zeros above them.
- R5: Each SCK half-period lasts divider system clocks. A divider of 0 acts as 1.
- R6: When a select goes low, the first SCK edge follows after exactly the pre-clock delay in clocks. A pre-clock delay of 0 means one half-period.
- R7: With hold=0 and forced-release=0, a word queued for the same slave before the current word ends is sent with the select kept low. Its first edge follows after the between-word delay, or after one half-period if that delay is 0. The select goes high after the last queued word.
- R8: With hold=1, the select stays low after a word until a word for a different slave is pending, and forced-release has no effect.
- R9: With forced-release=1 and hold=0, the select goes high after every word and stays high for at least the between-word delay in clocks, or at least 1 clock when that delay is 0.
- R10: Setup-word writes made while `cfg_wprot` is 1 are ignored.
- R11: At most one select line is low at any time.
- R12: A word is accepted when `tx_valid` and `tx_ready` are both 1, and `tx_ready` stays 0 while a word is pending. `rx_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup-word write strobe |
| cfg_wprot | input | 1 | Write protect; blocks setup-word writes |
| cfg_idx | input | 2 | Slave index of the setup word written |
| cfg_wdata | input | 32 | Setup word written |
| tx_valid | input | 1 | Word to send is offered |
| tx_cs | input | 2 | Target slave of the offered word |
| tx_data | input | 16 | Offered word, right-aligned |
| tx_ready | output | 1 | Holding register is empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low slave selects |
| rx_data | output | 16 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe marking a completed word |
| busy | output | 1 | Sequencer is not idle |

## Verification
On every cycle, the assertions check the following:
- only one select is ever low;
- locked setup words never change;
- a released select stays high for the minimum gap its policy demands;
- SCK is at its rest level when a word completes;
- the receive strobe lasts one cycle;
- a pending word stays unchanged.

Other behaviour shows only in the bench scenarios, which run the bench's own slave model over loopback: bit order and sampling edge for each mode, word length, the measured lead time and half-period, and the select staying low or going high across queued words under each policy.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int LEN_W  = 5;
    localparam int EDGE_W = LEN_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] between;
        logic [CNT_W-1:0] pre;
        logic [CNT_W-1:0] div;
        logic [3:0]       bits;
        logic             hold;
        logic             force_rel;
        logic             phase;
        logic             cpol;
    } cs_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP
    } seq_state_t;

    function automatic logic [LEN_W-1:0] xfer_len(input logic [3:0] code);
        return (code > 4'd8) ? LEN_W'(16) : LEN_W'(8 + code);
    endfunction

    function automatic logic [CNT_W-1:0] half_per(input cs_cfg_t c);
        return (c.div == '0) ? CNT_W'(1) : c.div;
    endfunction

    function automatic logic [CNT_W-1:0] lead_delay(input cs_cfg_t c);
        return (c.pre == '0) ? half_per(c) : c.pre;
    endfunction

    function automatic logic [CNT_W-1:0] word_spacing(input cs_cfg_t c);
        return (c.between == '0) ? half_per(c) : c.between;
    endfunction

    function automatic logic [CNT_W-1:0] release_gap(input cs_cfg_t c);
        if (c.force_rel && !c.hold && c.between != '0)
            return c.between;
        return CNT_W'(1);
    endfunction

endpackage

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
    import spi_cs_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            wprot,
    input  logic [CS_W-1:0] idx,
    input  logic [31:0]     wdata,
    output cs_cfg_t         cfg_o [NUM_CS]
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
        cs_cfg_t slot_q;

        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (we && !wprot && idx == CS_W'(g))
                slot_q <= cs_cfg_t'(wdata);
        end

        assign cfg_o[g] = slot_q;

        AST_WP_LOCK: assert property (@(posedge clk) disable iff (rst)
            wprot |=> $stable(slot_q)); // R10
    end

endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold
    import spi_cs_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CS_W-1:0]   in_cs,
    input  logic [DATA_W-1:0] in_data,
    input  logic              take,
    output logic              in_ready,
    output logic              hold_v,
    output logic [CS_W-1:0]   hold_cs,
    output logic [DATA_W-1:0] hold_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v    <= 1'b0;
            hold_cs   <= '0;
            hold_data <= '0;
        end else if (in_valid && !hold_v) begin
            hold_v    <= 1'b1;
            hold_cs   <= in_cs;
            hold_data <= in_data;
        end else if (take) begin
            hold_v <= 1'b0;
        end
    end

    assign in_ready = !hold_v;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (hold_v && !take) |=> ($stable(hold_data) && $stable(hold_cs) && hold_v)); // R12

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_cs_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  cs_cfg_t           cfg_i [NUM_CS],
    input  logic              pend_v,
    input  logic [CS_W-1:0]   pend_cs,
    input  logic [DATA_W-1:0] pend_data,
    output logic              take,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy
);

    seq_state_t        st;
    cs_cfg_t           cur;
    cs_cfg_t           nxt;
    logic [CS_W-1:0]   cur_cs;
    logic              held;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  hcnt;
    logic [EDGE_W-1:0] ecnt;
    logic [DATA_W-1:0] txsr;
    logic [DATA_W-1:0] rxsr;
    logic [DATA_W-1:0] aligned;
    logic [NUM_CS-1:0] sel_n;
    logic [EDGE_W-1:0] last_edge;
    logic              edge_now, done, sample_now, cont, start_idle, swap_cs;

    always_comb begin
        nxt       = cfg_i[pend_cs];
        aligned   = pend_data << (DATA_W - int'(xfer_len(nxt.bits)));
        last_edge = {xfer_len(cur.bits), 1'b0};
        for (int i = 0; i < NUM_CS; i++)
            sel_n[i] = (pend_cs != CS_W'(i));
    end

    assign done       = (st == ST_SHIFT) && (hcnt == '0) && (ecnt == last_edge);
    assign edge_now   = ((st == ST_SETUP) && (cnt == CNT_W'(1))) ||
                        ((st == ST_SHIFT) && (hcnt == '0) && (ecnt != last_edge));
    assign sample_now = edge_now && ((~ecnt[0]) == cur.phase);
    assign cont       = pend_v && (pend_cs == cur_cs) && (cur.hold || !cur.force_rel);
    assign swap_cs    = (st == ST_IDLE) && pend_v && held && (pend_cs != cur_cs);
    assign start_idle = (st == ST_IDLE) && pend_v && !swap_cs;
    assign take       = start_idle || (done && cont);
    assign busy       = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur      <= '0;
            cur_cs   <= '0;
            held     <= 1'b0;
            cnt      <= '0;
            hcnt     <= '0;
            ecnt     <= '0;
            txsr     <= '0;
            rxsr     <= '0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
            cs_n     <= '1;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (edge_now) begin
                sck  <= ~sck;
                ecnt <= ecnt + 1'b1;
                hcnt <= half_per(cur) - 1'b1;
                if (sample_now) begin
                    rxsr <= {rxsr[DATA_W-2:0], miso};
                end else begin
                    mosi <= txsr[DATA_W-1];
                    txsr <= txsr << 1;
                end
            end
            case (st)
                ST_SETUP: begin
                    if (cnt == CNT_W'(1)) st <= ST_SHIFT;
                    else                  cnt <= cnt - 1'b1;
                end
                ST_SHIFT: begin
                    if (hcnt != '0) hcnt <= hcnt - 1'b1;
                    if (done) begin
                        rx_valid <= 1'b1;
                        rx_data  <= rxsr;
                        if (cur.hold) begin
                            st <= ST_IDLE;
                        end else begin
                            st   <= ST_GAP;
                            cs_n <= '1;
                            held <= 1'b0;
                            cnt  <= release_gap(cur);
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt <= CNT_W'(1)) st <= ST_IDLE;
                    else                  cnt <= cnt - 1'b1;
                end
                default: begin
                    if (swap_cs) begin
                        st   <= ST_GAP;
                        cs_n <= '1;
                        held <= 1'b0;
                        cnt  <= CNT_W'(1);
                    end
                end
            endcase
            if (take) begin
                st     <= ST_SETUP;
                cur    <= nxt;
                cur_cs <= pend_cs;
                cs_n   <= sel_n;
                held   <= 1'b1;
                rxsr   <= '0;
                ecnt   <= '0;
                cnt    <= start_idle ? lead_delay(nxt) : word_spacing(nxt);
                if (start_idle) sck <= nxt.cpol;
                if (nxt.phase) begin
                    mosi <= aligned[DATA_W-1];
                    txsr <= aligned << 1;
                end else begin
                    txsr <= aligned;
                end
            end
        end
    end

    // Checker state: release gap bookkeeping
    logic [CNT_W:0] hi_run;
    logic [CNT_W:0] gap_need;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run   <= '0;
            gap_need <= '0;
        end else begin
            if (!(&cs_n))             hi_run <= '0;
            else if (!(&hi_run))      hi_run <= hi_run + 1'b1;
            if ((&cs_n) && hi_run == '0)
                gap_need <= {1'b0, release_gap(cur)};
        end
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1); // R11
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        (!(&cs_n) && $past(&cs_n)) |-> (hi_run >= gap_need)); // R9
    AST_SCK_REST: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (sck == cur.cpol)); // R2
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R12

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_wprot,
    input  logic [CS_W-1:0]   cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              tx_valid,
    input  logic [CS_W-1:0]   tx_cs,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy
);

    cs_cfg_t           cfg_w [NUM_CS];
    logic              pend_v, take;
    logic [CS_W-1:0]   pend_cs;
    logic [DATA_W-1:0] pend_data;

    spi_cfg_bank #(.NUM_CS(NUM_CS)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wprot(cfg_wprot),
        .idx(cfg_idx), .wdata(cfg_wdata), .cfg_o(cfg_w)
    );

    spi_tx_hold #(.NUM_CS(NUM_CS)) u_hold (
        .clk(clk), .rst(rst), .in_valid(tx_valid), .in_cs(tx_cs),
        .in_data(tx_data), .take(take), .in_ready(tx_ready),
        .hold_v(pend_v), .hold_cs(pend_cs), .hold_data(pend_data)
    );

    spi_xfer_engine #(.NUM_CS(NUM_CS)) u_eng (
        .clk(clk), .rst(rst), .cfg_i(cfg_w), .pend_v(pend_v),
        .pend_cs(pend_cs), .pend_data(pend_data), .take(take),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy)
    );

endmodule

// File: tb/spi_cs_seq_tb_top.sv
module spi_cs_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_wprot = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        tx_valid = 1'b0;
    logic [1:0]  tx_cs = '0;
    logic [15:0] tx_data = '0;
    logic        tx_ready, sck, mosi, miso, rx_valid, busy;
    logic [3:0]  cs_n;
    logic [15:0] rx_data;

    assign miso = mosi;

    always #10 clk = ~clk;

    spi_cs_seq dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wprot(cfg_wprot),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .tx_valid(tx_valid),
        .tx_cs(tx_cs), .tx_data(tx_data), .tx_ready(tx_ready), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] bcfg [4];

    // slave / line monitor
    int cyc = 0, t_fall = 0, last_edge = 0, first_delay = 0, half_meas = 0;
    int hi_run = 0, fall_gap = 0, rises = 0, multi = 0, rx_cnt = 0, rxv_long = 0;
    int slv_n = 0;
    bit first_seen = 0, m_cpol = 0, m_phase = 0, prev_low = 0, prev_sck = 0, prev_rxv = 0;
    logic [15:0] slv = '0, rx_last = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit any_low = !(&cs_n);
            if (any_low && !prev_low) begin
                t_fall = cyc; first_seen = 0; fall_gap = hi_run;
            end
            if (!any_low && prev_low) rises++;
            if (&cs_n) hi_run++; else hi_run = 0;
            if ($countones(~cs_n) > 1) multi++;
            if (any_low && prev_low && sck != prev_sck) begin
                automatic bit lead = (prev_sck == m_cpol);
                if (!first_seen) begin first_delay = cyc - t_fall; first_seen = 1; end
                else half_meas = cyc - last_edge;
                last_edge = cyc;
                if (lead == m_phase) begin slv = {slv[14:0], mosi}; slv_n++; end
            end
            if (rx_valid) begin
                rx_cnt++; rx_last = rx_data;
                if (prev_rxv) rxv_long++;
            end
            prev_low = any_low; prev_sck = sck; prev_rxv = rx_valid;
        end
    end

    function automatic int blen(input logic [3:0] code);
        return (code > 4'd8) ? 16 : 8 + code;
    endfunction

    function automatic logic [15:0] lmask(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic [31:0] mkcfg(input int betw, input int pre, input int dv,
                                          input int bits, input bit hold, input bit frc,
                                          input bit ph, input bit pol);
        return {8'(betw), 8'(pre), 8'(dv), 4'(bits), hold, frc, ph, pol};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input int idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!cfg_wprot) bcfg[idx] = w;
    endtask

    task automatic push(input int cs, input logic [15:0] d);
        int lim = 0;
        @(negedge clk);
        while (!tx_ready && lim < 5000) begin @(negedge clk); lim++; end
        tx_valid = 1'b1; tx_cs = 2'(cs); tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        int lim = 0;
        while (rx_cnt < n && lim < 5000) begin @(negedge clk); lim++; end
        if (rx_cnt < n) check("R12 rx timeout", 32'(rx_cnt), 32'(n));
    endtask

    task automatic arm(input int cs);
        m_cpol = bcfg[cs][0]; m_phase = bcfg[cs][1];
        slv = '0; slv_n = 0; rx_cnt = 0; rises = 0;
    endtask

    task automatic single(input int cs, input logic [15:0] d, input string tag);
        int n, hp, ld;
        n  = blen(bcfg[cs][7:4]);
        hp = (bcfg[cs][15:8] == 0) ? 1 : int'(bcfg[cs][15:8]);
        ld = (bcfg[cs][23:16] == 0) ? hp : int'(bcfg[cs][23:16]);
        arm(cs);
        push(cs, d);
        wait_rx(1);
        repeat (4) @(negedge clk);
        check({tag, " R4 rx word"}, 32'(rx_last), 32'(d & lmask(n)));
        check({tag, " R3 slave word"}, 32'(slv & lmask(n)), 32'(d & lmask(n)));
        check({tag, " R4 bit count"}, 32'(slv_n), 32'(n));
        check({tag, " R6 lead delay"}, 32'(first_delay), 32'(ld));
        check({tag, " R5 half period"}, 32'(half_meas), 32'(hp));
        check({tag, " R7 released"}, 32'(cs_n), 32'hF);
        check({tag, " R2 sck rest"}, 32'(sck), 32'(bcfg[cs][0]));
    endtask

    initial begin
        for (int i = 0; i < 4; i++) bcfg[i] = '0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 tx_ready", 32'(tx_ready), 32'h1);
        check("R1 cs_n", 32'(cs_n), 32'hF);
        check("R1 sck", 32'(sck), 32'h0);
        check("R12 rx_valid idle", 32'(rx_valid), 32'h0);
        single(3, 16'hA5C3, "R1 default");

        // R10: protected write leaves old setup in force
        cfg_wprot = 1'b1;
        wr_cfg(3, mkcfg(0, 0, 2, 8, 0, 0, 1, 1));
        cfg_wprot = 1'b0;
        single(3, 16'h1234, "R10 locked");

        // R7: queued word on same slave keeps select low
        wr_cfg(1, mkcfg(0, 3, 2, 0, 0, 0, 0, 0));
        arm(1);
        push(1, 16'h0011);
        push(1, 16'h0022);
        check("R12 ready low while pending", 32'(tx_ready), 32'h0);
        wait_rx(2);
        repeat (4) @(negedge clk);
        check("R7 one release", 32'(rises), 32'h1);
        check("R7 second word", 32'(rx_last), 32'h22);

        // R9: forced release with minimum gap
        wr_cfg(1, mkcfg(5, 2, 1, 0, 0, 1, 1, 0));
        arm(1);
        push(1, 16'h00F0);
        push(1, 16'h000F);
        wait_rx(2);
        repeat (8) @(negedge clk);
        check("R9 release per word", 32'(rises), 32'h2);
        check("R9 gap at least 5", 32'(fall_gap >= 5), 32'h1);
        check("R9 second word", 32'(rx_last), 32'h0F);

        // R8: hold policy, forced release ignored
        wr_cfg(2, mkcfg(3, 1, 1, 4, 1, 1, 0, 1));
        arm(2);
        push(2, 16'h0ABC);
        wait_rx(1);
        repeat (20) @(negedge clk);
        check("R8 held after word", 32'(cs_n), 32'hB);
        check("R4 12-bit word", 32'(rx_last), 32'hABC);
        push(2, 16'h0123);
        wait_rx(2);
        repeat (6) @(negedge clk);
        check("R8 no release same slave", 32'(rises), 32'h0);
        check("R8 still held", 32'(cs_n), 32'hB);
        m_cpol = bcfg[0][0]; m_phase = bcfg[0][1];
        push(0, 16'h005A);
        wait_rx(3);
        repeat (6) @(negedge clk);
        check("R8 released on other slave", 32'(rises), 32'h2);
        check("R8 all high", 32'(cs_n), 32'hF);
        check("R8 other slave word", 32'(rx_last), 32'h5A);

        // Random configurations
        for (int k = 0; k < 24; k++) begin
            int cs = int'($urandom % 4);
            wr_cfg(cs, mkcfg(int'($urandom % 4), int'($urandom % 5), int'($urandom % 4),
                             int'($urandom % 16), 1'b0, 1'($urandom % 2),
                             1'($urandom % 2), 1'($urandom % 2)));
            single(cs, 16'($urandom), "RND");
        end

        check("R11 single select", 32'(multi), 32'h0);
        check("R12 rx pulse width", 32'(rxv_long), 32'h0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R12 actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule